// File: doc/BRIEF.md
# Two-Pulse-Train Frequency Comparator

This block watches two pulse trains whose relative rate is not known in advance and decides which one runs faster. It does not count pulses and needs no timebase. Instead it remembers which input produced the most recent rising edge. When one input produces two rising edges in a row, with no edge from the other input in between, that input must be the faster train. The slower train can never do this, because an edge from the faster train always falls between two of its edges.

Both pulse inputs are asynchronous to the system clock. Each passes through a synchronizer chain of configurable length and then through a rising-edge detector. A small tracker holds the "most recent edge" state, which may be none, A or B. A verdict latch raises one of two sticky indicator outputs. That output stays high until the active-low reset is asserted. The reset is also the control that clears the indication.

Top module: `freq_compare`

## Requirements
- R1: While reset is asserted and immediately after it is released, `a_faster` and `b_faster` are both low, and the most-recent-edge state is set to "none".
- R2: Two rising edges on `pulse_a` with no rising edge on `pulse_b` between them set `a_faster` to 1.
- R3: Two rising edges on `pulse_b` with no rising edge on `pulse_a` between them set `b_faster` to 1.
- R4: The first rising edge after reset, from either input, sets no indicator.
- R5: Inputs whose edges strictly alternate (A, B, A, B, ...) set no indicator.
- R6: Rising edges seen on both inputs in the same clock cycle set no indicator and reset the most-recent-edge state to "none". A single edge that follows therefore sets no indicator either.
- R7: Once an indicator is high it stays high until reset. A later detection for the other side is ignored, so the two outputs are never high together.
- R8: With the default two-stage synchronizer, if an input pin rises before clock edge k and this edge completes a same-side pair, the matching indicator is low after edges k and k+1 and high after edge k+2. In general the delay is SYNC_STAGES+1 edges.
- R9: Two periodic trains whose periods are in the ratio 5:6 raise the indicator of the shorter-period input, whichever pin carries it, and never the other indicator.
- R10: Pulses only one clock cycle wide are detected exactly as wider pulses are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than either pulse train |
| rst_n | input | 1 | Active-low asynchronous reset; also clears the indication |
| pulse_a | input | 1 | Asynchronous pulse train A |
| pulse_b | input | 1 | Asynchronous pulse train B |
| a_faster | output | 1 | Sticky flag: train A has the higher rate |
| b_faster | output | 1 | Sticky flag: train B has the higher rate |

## Verification
The assertions assume that every pulse stays high for at least one full clock cycle. They also assume that consecutive pulses on the same pin are separated by at least one low cycle, so that each synchronized pulse gives exactly one detected rising edge. The bench changes the pins only at falling clock edges, with widths of one or more cycles and low gaps of several cycles. Ties are made by raising both pins at the same falling edge, which puts both synchronized edges in the same cycle.

// File: rtl/freqcmp_pkg.sv
`timescale 1ns/1ps
package freqcmp_pkg;

   // Source of the most recent synchronized rising edge.
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_A    = 2'd1,
      SRC_B    = 2'd2
   } src_e;

   // Smallest synchronizer chain accepted for an asynchronous input.
   localparam int unsigned MIN_SYNC_STAGES = 2;

   // Number of compared pulse inputs; the structure below is built for a pair.
   localparam int unsigned NUM_TRAINS = 2;

endpackage

// File: rtl/pulse_edge_sync.sv
`timescale 1ns/1ps
module pulse_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   import freqcmp_pkg::*;

   localparam int unsigned TOP = STAGES - 1;

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
         $error("pulse_edge_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         held_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         held_q  <= chain_q[TOP];
      end
   end

   // One-cycle strobe on a low-to-high change of the synchronized level.
   assign rise = chain_q[TOP] & ~held_q;

endmodule

// File: rtl/last_src_tracker.sv
`timescale 1ns/1ps
module last_src_tracker (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rise_a,
   input  logic                   rise_b,
   output freqcmp_pkg::src_e      last_src,
   output logic                   hit_a,
   output logic                   hit_b
);
   import freqcmp_pkg::*;

   src_e state_q;
   src_e state_d;

   always_comb begin
      unique case ({rise_a, rise_b})
         2'b10:   state_d = SRC_A;
         2'b01:   state_d = SRC_B;
         2'b11:   state_d = SRC_NONE;
         default: state_d = state_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SRC_NONE;
      else        state_q <= state_d;
   end

   // A lone edge that repeats the previous source is a back-to-back pair.
   assign hit_a    = rise_a & ~rise_b & (state_q == SRC_A);
   assign hit_b    = rise_b & ~rise_a & (state_q == SRC_B);
   assign last_src = state_q;

endmodule

// File: rtl/verdict_latch.sv
`timescale 1ns/1ps
module verdict_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_a,
   input  logic hit_b,
   output logic a_flag,
   output logic b_flag
);
   logic a_q;
   logic b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else if (!a_q && !b_q) begin
         if (hit_a)      a_q <= 1'b1;
         else if (hit_b) b_q <= 1'b1;
      end
   end

   assign a_flag = a_q;
   assign b_flag = b_q;

endmodule

// File: rtl/freq_compare.sv
`timescale 1ns/1ps
module freq_compare #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_a,
   input  logic pulse_b,
   output logic a_faster,
   output logic b_faster
);
   import freqcmp_pkg::*;

   localparam int unsigned IDX_A = 0;
   localparam int unsigned IDX_B = 1;

   logic [NUM_TRAINS-1:0] pin_vec;
   logic [NUM_TRAINS-1:0] rise_vec;
   src_e                  last_src;
   logic                  hit_a;
   logic                  hit_b;

   assign pin_vec[IDX_A] = pulse_a;
   assign pin_vec[IDX_B] = pulse_b;

   generate
      for (genvar gi = 0; gi < NUM_TRAINS; gi++) begin : g_train
         pulse_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (pin_vec[gi]),
            .rise     (rise_vec[gi])
         );
      end
   endgenerate

   last_src_tracker u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_a   (rise_vec[IDX_A]),
      .rise_b   (rise_vec[IDX_B]),
      .last_src (last_src),
      .hit_a    (hit_a),
      .hit_b    (hit_b)
   );

   verdict_latch u_verdict (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_a  (hit_a),
      .hit_b  (hit_b),
      .a_flag (a_faster),
      .b_flag (b_faster)
   );

endmodule

// File: rtl/freq_compare_checker.sv
`timescale 1ns/1ps
module freq_compare_checker (
   input logic              clk,
   input logic              rst_n,
   input logic              rise_a,
   input logic              rise_b,
   input freqcmp_pkg::src_e last_src,
   input logic              a_faster,
   input logic              b_faster
);
   import freqcmp_pkg::*;

   AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_faster && b_faster)); // R7

   AST_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      a_faster |=> a_faster); // R7

   AST_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      b_faster |=> b_faster); // R7

   AST_A_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(a_faster) |-> $past(rise_a && !rise_b && last_src == SRC_A)); // R2

   AST_B_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_faster) |-> $past(rise_b && !rise_a && last_src == SRC_B)); // R3

   AST_TIE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_a && rise_b) |=> (last_src == SRC_NONE)); // R6

   AST_TIE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_a && rise_b && !a_faster && !b_faster) |=> (!a_faster && !b_faster)); // R6

   AST_EDGE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_a |=> !rise_a); // R10

endmodule

bind freq_compare freq_compare_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rise_a   (rise_vec[0]),
   .rise_b   (rise_vec[1]),
   .last_src (last_src),
   .a_faster (a_faster),
   .b_faster (b_faster)
);

// File: tb/freq_compare_bench.sv
`timescale 1ns/1ps
module freq_compare_bench;

   typedef struct {
      logic  exp_a;
      logic  exp_b;
      string tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pulse_a = 1'b0;
   logic pulse_b = 1'b0;
   logic a_faster;
   logic b_faster;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   item_t sb_q[$];
   event  sample_ev;

   always #4 clk = ~clk;

   freq_compare u_freq_compare (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_a  (pulse_a),
      .pulse_b  (pulse_b),
      .a_faster (a_faster),
      .b_faster (b_faster)
   );

   // Monitor: drains the scoreboard and compares against the outputs.
   initial begin
      forever begin
         @(sample_ev);
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (a_faster !== it.exp_a || b_faster !== it.exp_b) begin
               errors++;
               $display("FAIL %s: a_faster=%b b_faster=%b expected a_faster=%b b_faster=%b",
                        it.tag, a_faster, b_faster, it.exp_a, it.exp_b);
            end
         end
      end
   end

   task automatic expect_flags(input logic ea, input logic eb, input string tag);
      item_t it;
      it.exp_a = ea;
      it.exp_b = eb;
      it.tag   = tag;
      sb_q.push_back(it);
      -> sample_ev;
      #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic da, input logic db, input int width);
      @(negedge clk);
      pulse_a = da;
      pulse_b = db;
      repeat (width) @(negedge clk);
      pulse_a = 1'b0;
      pulse_b = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      pulse_a = 1'b0;
      pulse_b = 1'b0;
      idle(3);
      expect_flags(1'b0, 1'b0, "R1 during reset");
      rst_n = 1'b1;
      idle(2);
      expect_flags(1'b0, 1'b0, "R1 after release");
   endtask

   task automatic train_a(input int offset, input int period, input int count);
      repeat (offset) @(negedge clk);
      for (int i = 0; i < count; i++) begin
         pulse_a = 1'b1;
         repeat (3) @(negedge clk);
         pulse_a = 1'b0;
         repeat (period - 3) @(negedge clk);
      end
   endtask

   task automatic train_b(input int offset, input int period, input int count);
      repeat (offset) @(negedge clk);
      for (int i = 0; i < count; i++) begin
         pulse_b = 1'b1;
         repeat (3) @(negedge clk);
         pulse_b = 1'b0;
         repeat (period - 3) @(negedge clk);
      end
   endtask

   // Driver
   initial begin
      do_reset();

      // R4: a lone first edge never decides
      pulse(1'b1, 1'b0, 3);
      idle(10);
      expect_flags(1'b0, 1'b0, "R4 first edge");

      // R5: alternating edges B, A, B
      pulse(1'b0, 1'b1, 3); idle(6);
      pulse(1'b1, 1'b0, 3); idle(6);
      pulse(1'b0, 1'b1, 3); idle(6);
      expect_flags(1'b0, 1'b0, "R5 alternating");

      // R6: simultaneous edges clear the state; one following B edge does not decide
      pulse(1'b1, 1'b1, 3); idle(10);
      expect_flags(1'b0, 1'b0, "R6 tie");
      pulse(1'b0, 1'b1, 3); idle(10);
      expect_flags(1'b0, 1'b0, "R6 edge after tie");

      // R8 and R3: state is B, a second B edge completes the pair
      @(negedge clk);
      pulse_b = 1'b1;
      @(negedge clk);
      expect_flags(1'b0, 1'b0, "R8 after edge k");
      @(negedge clk);
      expect_flags(1'b0, 1'b0, "R8 after edge k+1");
      @(negedge clk);
      expect_flags(1'b0, 1'b1, "R8 R3 after edge k+2");
      pulse_b = 1'b0;
      idle(6);

      // R7: A pairs after B was decided are ignored
      pulse(1'b1, 1'b0, 3); idle(6);
      pulse(1'b1, 1'b0, 3); idle(6);
      pulse(1'b1, 1'b0, 3); idle(8);
      expect_flags(1'b0, 1'b1, "R7 sticky");

      do_reset();

      // R2 and R10: single-cycle A pulses
      pulse(1'b1, 1'b0, 1); idle(6);
      expect_flags(1'b0, 1'b0, "R10 one pulse");
      pulse(1'b1, 1'b0, 1); idle(6);
      expect_flags(1'b1, 1'b0, "R2 R10 narrow pair");

      do_reset();

      // R9: A has period 40, B has period 48
      fork
         train_a(0, 40, 8);
         train_b(20, 48, 7);
      join
      expect_flags(1'b1, 1'b0, "R9 A faster");

      do_reset();

      // R9: B has period 40, A has period 48
      fork
         train_b(0, 40, 8);
         train_a(20, 48, 7);
      join
      expect_flags(1'b0, 1'b1, "R9 B faster");

      done = 1'b1;
      idle(2);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule